// File: doc/BRIEF.md
# Stereo Receive FIFO Pair

This block buffers received audio samples in two matched FIFOs, one holding left-channel words and one holding right-channel words. On the audio side, a serial receiver hands over one stereo pair per push: a left word and a right word arrive in the same cycle and are stored together. On the processor side, a bus port pops one word per access. A select input chooses the left or the right FIFO, and the word appears on a registered read-data output. Software may drain the two channels in any order it likes, such as interleaved, all right first, or all left first.

Three sticky status bits report the state of the pair. The first is set when both FIFOs are full. The second is set by any overflow or underflow. The third is set when the hardware has realigned the channels. Each bit is cleared by writing a one to its position in a clear strobe.

A full channel refuses the whole incoming pair, so an overrun on the audio side never splits a pair. An unequal number of processor pops can still leave the FIFOs misaligned. With auto-resync enabled, the block checks alignment on every arriving pair and discards the oldest surplus entries of the fuller FIFO before storing the new pair.

Top module: `stereo_rx_pair`

## Requirements
- R1: After reset, both levels read 0, all three status bits are 0 and the read-data output is 0.
- R2: A push stores its left word in the left FIFO and its right word in the right FIFO. A read with the select low pops the oldest left word, and a read with the select high pops the oldest right word. The popped word appears on the read-data output from the clock edge that takes the read, and each level rises by one per push and falls by one per pop.
- R3: The order in which the two channels are read has no effect on the word sequence each channel returns.
- R4: Status bit 0 (full) becomes set in the cycle after both levels equal DEPTH, and never while only one FIFO is full.
- R5: A push while either FIFO already holds DEPTH entries (after any pop in the same cycle) stores neither word, leaves both levels unchanged and sets status bit 1 (under/overrun).
- R6: A read from an empty FIFO leaves its level at 0, returns the last word popped from that channel (0 if none since reset) and sets status bit 1.
- R7: Each status bit stays set until a clear strobe carries a one at its position (bit 0 full, bit 1 under/overrun, bit 2 resync). Zeros in the mask leave bits untouched, and a new event in the clearing cycle keeps the bit set.
- R8: With auto-resync enabled, a push that finds the two levels unequal (after any same-cycle pop) first drops the oldest surplus words from the fuller FIFO so that both levels match, then stores the pair and sets status bit 2.
- R9: With auto-resync disabled, unequal levels are kept across pushes and status bit 2 is never set.
- R10: A pop and a push in the same cycle on a full FIFO are both accepted: the pop frees the slot that the push fills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Audio side presents one stereo pair |
| push_left | input | DATA_W | Left word of the pair |
| push_right | input | DATA_W | Right word of the pair |
| rd_en | input | 1 | Processor read access |
| rd_right | input | 1 | Read select: 0 left FIFO, 1 right FIFO |
| rd_data | output | DATA_W | Registered word returned by the last read |
| resync_en | input | 1 | Enables automatic realignment on push |
| clr_wr | input | 1 | Clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask for the status bits |
| lvl_left | output | $clog2(DEPTH+1) | Left FIFO occupancy |
| lvl_right | output | $clog2(DEPTH+1) | Right FIFO occupancy |
| stat_full | output | 1 | Sticky: both FIFOs were full |
| stat_unov | output | 1 | Sticky: an overflow or underflow occurred |
| stat_resync | output | 1 | Sticky: the hardware realigned the channels |

## Verification
A pointer or count that drifts between the two channels shows at the ports as unequal levels after paired pushes. It also shows one read later as a word from the wrong position of the sample stream on the read-data output. A trim of the wrong size or on the wrong side shows in the first read after the realigning push, because the returned word no longer matches the pairing the scoreboard expects. Faults in the sticky status bits show within one cycle of the triggering event or of a clear strobe.

// File: rtl/stfifo_pkg.sv
package stfifo_pkg;

  localparam int N_STAT = 3;

  // Status bit positions inside the clear mask
  localparam int ST_FULL   = 0;
  localparam int ST_UNOV   = 1;
  localparam int ST_RESYNC = 2;

  // Entries by which one channel exceeds the other (0 when not ahead)
  function automatic int unsigned surplus(input int unsigned mine,
                                          input int unsigned other);
    return (mine > other) ? (mine - other) : 0;
  endfunction

  // Level a channel holds once a same-cycle pop is taken
  function automatic int unsigned after_pop(input int unsigned lvl,
                                            input logic pop);
    return pop ? (lvl - 1) : lvl;
  endfunction

endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  input  logic [CW-1:0] drop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] level
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr + AW'(pop) + AW'(drop);
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      cnt <= cnt + CW'(wr_en) - CW'(pop) - drop;
    end
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import stfifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          push_en,
  input  logic          rd_en,
  input  logic          rd_right,
  input  logic          resync_en,
  input  logic [CW-1:0] lvl_l,
  input  logic [CW-1:0] lvl_r,
  output logic          pop_l,
  output logic          pop_r,
  output logic [CW-1:0] drop_l,
  output logic [CW-1:0] drop_r,
  output logic          push_ok,
  output logic          under_ev,
  output logic          over_ev,
  output logic          trim_ev
);

  logic [CW-1:0] pa_l, pa_r, kept_l, kept_r;

  always_comb begin
    pop_l    = rd_en && !rd_right && (lvl_l != '0);
    pop_r    = rd_en &&  rd_right && (lvl_r != '0);
    under_ev = rd_en && (rd_right ? (lvl_r == '0) : (lvl_l == '0));

    pa_l = CW'(after_pop(int'(lvl_l), pop_l));
    pa_r = CW'(after_pop(int'(lvl_r), pop_r));

    trim_ev = push_en && resync_en && (pa_l != pa_r);
    drop_l  = trim_ev ? CW'(surplus(int'(pa_l), int'(pa_r))) : '0;
    drop_r  = trim_ev ? CW'(surplus(int'(pa_r), int'(pa_l))) : '0;

    kept_l  = pa_l - drop_l;
    kept_r  = pa_r - drop_r;
    push_ok = push_en && (kept_l < CW'(DEPTH)) && (kept_r < CW'(DEPTH));
    over_ev = push_en && !push_ok;
  end

endmodule

// File: rtl/status_bits.sv
module status_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[b] <= 1'b0;
      else        q[b] <= set[b] | (q[b] & ~clr[b]);
    end
  end

endmodule

// File: rtl/stereo_rx_pair.sv
module stereo_rx_pair
  import stfifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_left,
  input  logic [DATA_W-1:0] push_right,
  input  logic              rd_en,
  input  logic              rd_right,
  output logic [DATA_W-1:0] rd_data,
  input  logic              resync_en,
  input  logic              clr_wr,
  input  logic [2:0]        clr_mask,
  output logic [CW-1:0]     lvl_left,
  output logic [CW-1:0]     lvl_right,
  output logic              stat_full,
  output logic              stat_unov,
  output logic              stat_resync
);

  // Per-channel views: index 0 left, 1 right
  logic [DATA_W-1:0] head_v [2];
  logic [DATA_W-1:0] last_v [2];
  logic [DATA_W-1:0] wdat_v [2];
  logic [CW-1:0]     lvl_v  [2];
  logic [CW-1:0]     drop_v [2];
  logic [1:0]        pop_v;
  logic              push_ok;

  // Named internal events
  logic ev_under, ev_over, ev_resync, ev_full, ev_unov;
  logic [N_STAT-1:0] st_set, st_clr, st_q;

  assign wdat_v[0] = push_left;
  assign wdat_v[1] = push_right;

  align_ctrl #(.DEPTH(DEPTH)) u_align (
    .push_en   (push_en),
    .rd_en     (rd_en),
    .rd_right  (rd_right),
    .resync_en (resync_en),
    .lvl_l     (lvl_v[0]),
    .lvl_r     (lvl_v[1]),
    .pop_l     (pop_v[0]),
    .pop_r     (pop_v[1]),
    .drop_l    (drop_v[0]),
    .drop_r    (drop_v[1]),
    .push_ok   (push_ok),
    .under_ev  (ev_under),
    .over_ev   (ev_over),
    .trim_ev   (ev_resync)
  );

  for (genvar c = 0; c < 2; c++) begin : g_chan
    chan_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (push_ok),
      .wr_data (wdat_v[c]),
      .pop     (pop_v[c]),
      .drop    (drop_v[c]),
      .head    (head_v[c]),
      .level   (lvl_v[c])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)        last_v[c] <= '0;
      else if (pop_v[c]) last_v[c] <= head_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en)
      rd_data <= pop_v[rd_right] ? head_v[rd_right] : last_v[rd_right];
  end

  assign ev_full = (lvl_v[0] == CW'(DEPTH)) && (lvl_v[1] == CW'(DEPTH));
  assign ev_unov = ev_under || ev_over;

  assign st_set[ST_FULL]   = ev_full;
  assign st_set[ST_UNOV]   = ev_unov;
  assign st_set[ST_RESYNC] = ev_resync;
  assign st_clr            = clr_wr ? clr_mask : '0;

  status_bits #(.N(N_STAT)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (st_set),
    .clr   (st_clr),
    .q     (st_q)
  );

  assign stat_full   = st_q[ST_FULL];
  assign stat_unov   = st_q[ST_UNOV];
  assign stat_resync = st_q[ST_RESYNC];
  assign lvl_left    = lvl_v[0];
  assign lvl_right   = lvl_v[1];

endmodule

// File: rtl/stereo_rx_pair_chk.sv
module stereo_rx_pair_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_en,
  input logic          rd_en,
  input logic          rd_right,
  input logic          resync_en,
  input logic          clr_wr,
  input logic [2:0]    clr_mask,
  input logic [CW-1:0] lvl_left,
  input logic [CW-1:0] lvl_right,
  input logic          stat_full,
  input logic          stat_unov,
  input logic          stat_resync,
  input logic          ev_resync
);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_left <= CW'(DEPTH)) && (lvl_right <= CW'(DEPTH)));

  assert_full_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_left == CW'(DEPTH) && lvl_right == CW'(DEPTH)) |=> stat_full);

  assert_full_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_full) |-> $past(lvl_left == CW'(DEPTH) && lvl_right == CW'(DEPTH)));

  assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !rd_en && lvl_left == CW'(DEPTH) && lvl_right == CW'(DEPTH))
    |=> (lvl_left == CW'(DEPTH) && lvl_right == CW'(DEPTH) && stat_unov));

  assert_underrun_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_right && lvl_left == '0 && !push_en) |=> (stat_unov && lvl_left == '0));

  assert_sticky_unov_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_unov && !(clr_wr && clr_mask[1])) |=> stat_unov);

  assert_clear_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_mask[2] && !ev_resync) |=> !stat_resync);

  assert_resync_aligns_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resync |=> (lvl_left == lvl_right && stat_resync));

  assert_no_resync_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_en |-> !ev_resync);

endmodule

bind stereo_rx_pair stereo_rx_pair_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .push_en     (push_en),
  .rd_en       (rd_en),
  .rd_right    (rd_right),
  .resync_en   (resync_en),
  .clr_wr      (clr_wr),
  .clr_mask    (clr_mask),
  .lvl_left    (lvl_left),
  .lvl_right   (lvl_right),
  .stat_full   (stat_full),
  .stat_unov   (stat_unov),
  .stat_resync (stat_resync),
  .ev_resync   (ev_resync)
);

// File: tb/stereo_rx_pair_tb.sv
module stereo_rx_pair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int D  = 8;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_en = 1'b0;
  logic [W-1:0]  push_left = '0, push_right = '0;
  logic          rd_en = 1'b0, rd_right = 1'b0;
  logic [W-1:0]  rd_data;
  logic          resync_en = 1'b0;
  logic          clr_wr = 1'b0;
  logic [2:0]    clr_mask = '0;
  logic [CW-1:0] lvl_left, lvl_right;
  logic          stat_full, stat_unov, stat_resync;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stereo_rx_pair #(.DATA_W(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_left(push_left),
    .push_right(push_right), .rd_en(rd_en), .rd_right(rd_right),
    .rd_data(rd_data), .resync_en(resync_en), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .lvl_left(lvl_left), .lvl_right(lvl_right),
    .stat_full(stat_full), .stat_unov(stat_unov), .stat_resync(stat_resync)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // Scoreboard state: per-channel content, last popped word, read expectations
  logic [W-1:0] q_l[$];
  logic [W-1:0] q_r[$];
  logic [W-1:0] last_l = '0, last_r = '0;
  logic [W-1:0] exp_rd[$];
  bit mdl_resync = 0;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, model updated from the requirements
  task automatic cyc(input bit psh, input logic [W-1:0] l, input logic [W-1:0] r,
                     input bit rd, input bit side);
    logic [W-1:0] e;
    push_en = psh; push_left = l; push_right = r; rd_en = rd; rd_right = side;
    if (rd) begin
      if (!side) begin
        if (q_l.size() > 0) begin e = q_l.pop_front(); last_l = e; end
        else e = last_l;
      end else begin
        if (q_r.size() > 0) begin e = q_r.pop_front(); last_r = e; end
        else e = last_r;
      end
      exp_rd.push_back(e);
    end
    if (psh) begin
      if (mdl_resync && q_l.size() != q_r.size()) begin
        while (q_l.size() > q_r.size()) void'(q_l.pop_front());
        while (q_r.size() > q_l.size()) void'(q_r.pop_front());
      end
      if (q_l.size() < D && q_r.size() < D) begin
        q_l.push_back(l); q_r.push_back(r);
      end
    end
    @(negedge clk);
    push_en = 0; rd_en = 0; rd_right = 0;
  endtask

  task automatic push(input logic [W-1:0] l, input logic [W-1:0] r);
    cyc(1, l, r, 0, 0);
  endtask

  task automatic rd(input bit side);
    cyc(0, '0, '0, 1, side);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic clr(input logic [2:0] m);
    clr_wr = 1; clr_mask = m;
    @(negedge clk);
    clr_wr = 0; clr_mask = '0;
  endtask

  task automatic chk_lvl(input string req, input int l, input int r);
    chk(req, W'(lvl_left), W'(l));
    chk(req, W'(lvl_right), W'(r));
  endtask

  // Monitor: compares each read result one edge after the read is taken
  logic due = 0;
  always @(posedge clk) due <= rd_en;
  always @(negedge clk) begin
    if (due && rst_n) begin
      if (exp_rd.size() == 0) chk(cur_req, rd_data, 'x);
      else chk(cur_req, rd_data, exp_rd.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_lvl("R1", 0, 0);
    chk("R1", W'({stat_full, stat_unov, stat_resync}), '0);
    chk("R1", rd_data, '0);

    // R2 alternating reads
    cur_req = "R2";
    for (int i = 1; i <= 3; i++) push(W'(32'h100 + i), W'(32'h200 + i));
    chk_lvl("R2", 3, 3);
    for (int i = 0; i < 3; i++) begin rd(0); rd(1); end
    idle();
    chk_lvl("R2", 0, 0);

    // R3 all right then all left
    cur_req = "R3";
    for (int i = 1; i <= 4; i++) push(W'(32'h300 + i), W'(32'h400 + i));
    for (int i = 0; i < 4; i++) rd(1);
    for (int i = 0; i < 4; i++) rd(0);
    idle();
    chk_lvl("R3", 0, 0);

    // R4 full only when both full
    cur_req = "R4";
    for (int i = 1; i <= D - 1; i++) push(W'(32'h500 + i), W'(32'h600 + i));
    idle();
    chk("R4", W'(stat_full), 0);
    push(32'h5ff, 32'h6ff);
    idle();
    chk("R4", W'(stat_full), 1);
    rd(0);
    clr(3'b001);
    chk_lvl("R4", D - 1, D);
    chk("R4 one full", W'(stat_full), 0);

    // R5 overrun with right full discards the pair
    cur_req = "R5";
    push(32'hdead, 32'hbeef);
    chk_lvl("R5", D - 1, D);
    chk("R5", W'(stat_unov), 1);
    clr(3'b000);
    chk("R7 zero mask", W'(stat_unov), 1);
    clr(3'b010);
    chk("R7 clear", W'(stat_unov), 0);

    // R10 pop and push in the same cycle on a full right FIFO
    cur_req = "R10";
    cyc(1, 32'h7a1, 32'h7b1, 1, 1);
    chk_lvl("R10", D, D);
    chk("R10", W'(stat_unov), 0);

    // Drain then R6 underrun
    cur_req = "R2";
    for (int i = 0; i < D; i++) rd(0);
    for (int i = 0; i < D; i++) rd(1);
    clr(3'b111);
    cur_req = "R6";
    rd(0);
    chk_lvl("R6", 0, 0);
    chk("R6", W'(stat_unov), 1);
    rd(1);
    idle();

    // R8 automatic realignment
    clr(3'b111);
    resync_en = 1; mdl_resync = 1;
    cur_req = "R8";
    for (int i = 1; i <= 3; i++) push(W'(32'h800 + i), W'(32'h900 + i));
    rd(0); rd(0);
    chk("R8 before", W'(stat_resync), 0);
    push(32'h8aa, 32'h9aa);
    chk_lvl("R8", 2, 2);
    chk("R8", W'(stat_resync), 1);
    rd(0); rd(1); rd(0); rd(1);
    idle();

    // R9 no realignment when disabled
    clr(3'b111);
    resync_en = 0; mdl_resync = 0;
    cur_req = "R9";
    push(32'ha01, 32'hb01); push(32'ha02, 32'hb02);
    rd(0);
    push(32'ha03, 32'hb03);
    chk_lvl("R9", 2, 3);
    chk("R9", W'(stat_resync), 0);
    rd(0); rd(0); rd(1); rd(1); rd(1);
    idle();
    chk_lvl("R9", 0, 0);
    chk("R3 queue drained", W'(exp_rd.size()), 0);

    finish_run();
  end

endmodule